// File: doc/BRIEF.md
# Coast Window Generator

This block tells a line-locked clock loop when to stop tracking horizontal sync around the vertical interval. It counts horizontal sync strobes between successive vertical leading edges and keeps the count from the last complete frame. From that count it predicts where the next vertical pulse will land, and it raises coast a programmed number of lines early. Coast then stays high through the vertical pulse and for a programmed number of lines after the pulse ends.

A source select can replace the generated window with an external coast pin. The pin's active level can be forced by configuration. It can also be worked out automatically by measuring the pin's high and low phases and treating the shorter phase as active. The output `coast_o` is registered and always active high. Sync inputs arrive already normalized: `hs_strobe` is a one-cycle pulse per line and `vs_in` is high during vertical sync.

Top module: `coast_window_gen`

## Requirements
- R1: After reset, `coast_o` is 0 until an input event raises it.
- R2: With internal source, no early (precoast) window is produced before two vertical leading edges have been seen since reset. Only the vertical pulse and postcoast lines raise coast before that point.
- R3: Once a frame total T has been measured and `cfg_pre` is non-zero, coast rises in the line where the strobe count since the last vertical leading edge, plus `cfg_pre`, reaches T or more. It then stays high until the next vertical leading edge.
- R4: With `cfg_pre` = 0, coast does not rise before the vertical leading edge and rises at that edge.
- R5: Coast stays high for as long as `vs_in` is high.
- R6: After the vertical trailing edge, coast stays high until `cfg_post` further horizontal strobes have arrived, and drops after the last of them.
- R7: With `cfg_post` = 0, coast drops at the vertical trailing edge.
- R8: With `cfg_src_ext` = 1, `coast_o` follows the normalized external pin one clock after it, and vertical sync activity has no effect on it.
- R9: With `cfg_pol_force` = 1, `cfg_pol_level` = 1 means the pin is active high (passed as is) and 0 means active low (inverted).
- R10: With `cfg_pol_force` = 0, the pin is treated as active high if its last measured high phase is no longer than its last low phase, and as active low otherwise. Phase lengths saturate at 2^RUN_W-1 cycles. Until both phases have been measured, active high is assumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hs_strobe | input | 1 | One-cycle pulse per horizontal line |
| vs_in | input | 1 | Normalized vertical sync, high when active |
| ext_coast | input | 1 | External coast pin, raw polarity |
| cfg_src_ext | input | 1 | 0: generated window, 1: external pin |
| cfg_pol_force | input | 1 | 0: automatic pin polarity, 1: use cfg_pol_level |
| cfg_pol_level | input | 1 | Forced pin polarity, 1 = active high |
| cfg_pre | input | CNT_W | Lines of coast before vertical sync |
| cfg_post | input | CNT_W | Lines of coast after vertical sync |
| coast_o | output | 1 | Registered coast, active high |

## Verification
The bench builds the block with LINE_W = 8 and RUN_W = 6 and keeps CNT_W = 8. The narrow run counter puts phase-length saturation within a short stimulus: a 70-cycle low phase clips to 63, and the shorter high phase must still be chosen as active. The bench runs several frames with changing line totals and pre/post values. These cover the unmeasured first frame, a frame longer than predicted, and zero counts on both sides. Expected coast per line comes from a line-level model of the requirements.

// File: rtl/coast_pkg.sv
package coast_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_PRE  = 2'd1,
    WIN_VS   = 2'd2,
    WIN_POST = 2'd3
  } win_state_e;
endpackage

// File: rtl/coast_line_meter.sv
module coast_line_meter #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_strobe,
  input  logic              vs_rise,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic [LINE_W-1:0] total_o,
  output logic              valid_o
);
  localparam logic [LINE_W-1:0] CNT_MAX = '1;

  logic [LINE_W-1:0] cnt_q, cnt_d, tot_q, tot_d;
  logic              seen_q, seen_d, valid_q, valid_d;
  logic              cnt_en;

  assign cnt_en = vs_rise | hs_strobe;

  always_comb begin
    cnt_d   = cnt_q;
    tot_d   = tot_q;
    seen_d  = seen_q;
    valid_d = valid_q;
    if (vs_rise) begin
      tot_d   = cnt_q;
      cnt_d   = hs_strobe ? LINE_W'(1) : '0;
      seen_d  = 1'b1;
      valid_d = seen_q | valid_q;
    end else if (hs_strobe && cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + LINE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tot_q   <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      tot_q   <= tot_d;
      seen_q  <= seen_d;
      valid_q <= valid_d;
    end
  end

  assign line_cnt_o = cnt_q;
  assign total_o    = tot_q;
  assign valid_o    = valid_q;

  AST_VALID_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(vs_rise)); // R2
endmodule

// File: rtl/coast_window_fsm.sv
module coast_window_fsm
  import coast_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_strobe,
  input  logic              vs_rise,
  input  logic              vs_fall,
  input  logic              vs_level,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [LINE_W-1:0] total,
  input  logic              total_valid,
  input  logic [CNT_W-1:0]  cfg_pre,
  input  logic [CNT_W-1:0]  cfg_post,
  output logic              win_o
);
  localparam int SUM_W = ((LINE_W > CNT_W) ? LINE_W : CNT_W) + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  win_state_e       state_q, state_d;
  logic [CNT_W-1:0] post_q, post_d;
  logic [SUM_W-1:0] reach;
  logic             pre_hit;

  assign reach   = SUM_W'(line_cnt) + SUM_W'(cfg_pre);
  assign pre_hit = total_valid && (cfg_pre != '0) && (reach >= SUM_W'(total));

  always_comb begin
    state_d = state_q;
    post_d  = post_q;
    unique case (state_q)
      WIN_IDLE: begin
        if (vs_rise)      state_d = WIN_VS;
        else if (pre_hit) state_d = WIN_PRE;
      end
      WIN_PRE: begin
        if (vs_rise) state_d = WIN_VS;
      end
      WIN_VS: begin
        if (vs_fall) begin
          post_d  = cfg_post;
          state_d = (cfg_post == '0) ? WIN_IDLE : WIN_POST;
        end
      end
      WIN_POST: begin
        if (vs_rise) begin
          state_d = WIN_VS;
        end else if (hs_strobe) begin
          post_d = post_q - ONE;
          if (post_q == ONE) state_d = WIN_IDLE;
        end
      end
      default: state_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      post_q  <= '0;
    end else begin
      state_q <= state_d;
      post_q  <= post_d;
    end
  end

  assign win_o = (state_q != WIN_IDLE);

  AST_POST_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_POST) |-> (post_q != '0)); // R6
  AST_VS_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    vs_level |-> (state_q == WIN_VS)); // R5
  AST_NO_EARLY_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    !total_valid |-> (state_q != WIN_PRE)); // R2
  AST_PRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_IDLE && cfg_pre == '0) |=> (state_q != WIN_PRE)); // R4
endmodule

// File: rtl/coast_ext_polarity.sv
module coast_ext_polarity #(
  parameter int RUN_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_pin,
  input  logic cfg_pol_force,
  input  logic cfg_pol_level,
  output logic ext_norm_o
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  logic             ext_q;
  logic [RUN_W-1:0] run_q, run_d, hi_q, hi_d, lo_q, lo_d;
  logic             hi_v_q, hi_v_d, lo_v_q, lo_v_d;
  logic             chg, run_en, auto_pos, pol;

  assign chg    = ext_pin ^ ext_q;
  assign run_en = chg | (run_q != RUN_MAX);

  always_comb begin
    run_d  = run_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    hi_v_d = hi_v_q;
    lo_v_d = lo_v_q;
    if (chg) begin
      run_d = RUN_ONE;
      if (ext_q) begin
        hi_d   = run_q;
        hi_v_d = 1'b1;
      end else begin
        lo_d   = run_q;
        lo_v_d = 1'b1;
      end
    end else if (run_q != RUN_MAX) begin
      run_d = run_q + RUN_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
    end else begin
      ext_q <= ext_pin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= RUN_ONE;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      hi_v_q <= 1'b0;
      lo_v_q <= 1'b0;
    end else if (chg) begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      hi_v_q <= hi_v_d;
      lo_v_q <= lo_v_d;
    end
  end

  assign auto_pos   = !(hi_v_q && lo_v_q) || (hi_q <= lo_q);
  assign pol        = cfg_pol_force ? cfg_pol_level : auto_pos;
  assign ext_norm_o = pol ? ext_pin : ~ext_pin;

  AST_HI_LEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hi_v_q |-> (hi_q != '0)); // R10
  AST_LO_LEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    lo_v_q |-> (lo_q != '0)); // R10
endmodule

// File: rtl/coast_window_gen.sv
module coast_window_gen #(
  parameter int LINE_W = 12,
  parameter int CNT_W  = 8,
  parameter int RUN_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_strobe,
  input  logic             vs_in,
  input  logic             ext_coast,
  input  logic             cfg_src_ext,
  input  logic             cfg_pol_force,
  input  logic             cfg_pol_level,
  input  logic [CNT_W-1:0] cfg_pre,
  input  logic [CNT_W-1:0] cfg_post,
  output logic             coast_o
);
  logic              rst_meta_q, rst_s_n;
  logic              vs_q, vs_rise, vs_fall;
  logic [LINE_W-1:0] line_cnt, total;
  logic              total_valid, win, ext_norm, coast_d, coast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) vs_q <= 1'b0;
    else          vs_q <= vs_in;
  end

  assign vs_rise = vs_in & ~vs_q;
  assign vs_fall = ~vs_in & vs_q;

  coast_line_meter #(.LINE_W(LINE_W)) meter_i (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .hs_strobe  (hs_strobe),
    .vs_rise    (vs_rise),
    .line_cnt_o (line_cnt),
    .total_o    (total),
    .valid_o    (total_valid)
  );

  coast_window_fsm #(.LINE_W(LINE_W), .CNT_W(CNT_W)) fsm_i (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .hs_strobe   (hs_strobe),
    .vs_rise     (vs_rise),
    .vs_fall     (vs_fall),
    .vs_level    (vs_q),
    .line_cnt    (line_cnt),
    .total       (total),
    .total_valid (total_valid),
    .cfg_pre     (cfg_pre),
    .cfg_post    (cfg_post),
    .win_o       (win)
  );

  coast_ext_polarity #(.RUN_W(RUN_W)) pol_i (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .ext_pin       (ext_coast),
    .cfg_pol_force (cfg_pol_force),
    .cfg_pol_level (cfg_pol_level),
    .ext_norm_o    (ext_norm)
  );

  assign coast_d = cfg_src_ext ? ext_norm : win;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) coast_q <= 1'b0;
    else          coast_q <= coast_d;
  end

  assign coast_o = coast_q;

  AST_INT_VS_COAST: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cfg_src_ext && $past(!cfg_src_ext) && $past(vs_q)) |-> coast_q); // R5
  AST_FORCED_PASS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_src_ext && cfg_pol_force && cfg_pol_level) |=> (coast_q == $past(ext_coast))); // R9
endmodule

// File: tb/coast_window_gen_tb_top.sv
module coast_window_gen_tb_top;
  localparam int LINE_W = 8;
  localparam int CNT_W  = 8;
  localparam int RUN_W  = 6;

  logic             clk, rst_n, hs_strobe, vs_in, ext_coast;
  logic             cfg_src_ext, cfg_pol_force, cfg_pol_level;
  logic [CNT_W-1:0] cfg_pre, cfg_post;
  logic             coast_o;

  coast_window_gen #(.LINE_W(LINE_W), .CNT_W(CNT_W), .RUN_W(RUN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .hs_strobe(hs_strobe), .vs_in(vs_in),
    .ext_coast(ext_coast), .cfg_src_ext(cfg_src_ext),
    .cfg_pol_force(cfg_pol_force), .cfg_pol_level(cfg_pol_level),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .coast_o(coast_o)
  );

  typedef struct {
    int    due;
    logic  exp;
    string tag;
  } chk_t;

  chk_t  sb_q[$];
  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  bit    finished = 0;

  // line-level model state
  int b_cnt = 0, b_tot = 0, b_post_left = 0;
  bit b_seen = 0, b_valid = 0, b_vs = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expectations when due
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      chk_t it;
      it = sb_q.pop_front();
      total++;
      if (coast_o !== it.exp) begin
        bad++;
        $display("FAIL %s cycle %0d: coast_o actual=%b expected=%b", it.tag, cyc, coast_o, it.exp);
      end
    end
  end

  task automatic push_chk(input logic exp, input string tag, input int delay);
    chk_t it;
    it.due = cyc + delay;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic run_line(input bit rise, input bit fall);
    logic  exp;
    string tag;
    bit    pre_c;
    @(negedge clk);
    hs_strobe = 1'b1;
    if (b_cnt < 255) b_cnt++;
    if (b_post_left > 0) b_post_left--;
    @(negedge clk);
    hs_strobe = 1'b0;
    @(negedge clk);
    if (rise) begin
      vs_in = 1'b1;
      b_vs = 1;
      b_post_left = 0;
      if (b_seen) begin
        b_tot = b_cnt;
        b_valid = 1;
      end
      b_seen = 1;
      b_cnt = 0;
    end
    if (fall) begin
      vs_in = 1'b0;
      b_vs = 0;
      b_post_left = int'(cfg_post);
    end
    repeat (3) @(negedge clk);
    pre_c = b_valid && (cfg_pre != 0) && (b_cnt + int'(cfg_pre) >= b_tot);
    exp = b_vs || (b_post_left > 0) || pre_c;
    if (b_vs)                 tag = "R5 vs active";
    else if (b_post_left > 0) tag = "R6 postcoast";
    else if (pre_c)           tag = "R3 precoast";
    else if (!b_valid)        tag = "R2 unmeasured frame";
    else if (cfg_pre == 0)    tag = "R4/R7 zero counts";
    else                      tag = "R6 window closed";
    push_chk(exp, tag, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_frame(input int nlines, input int vlines);
    for (int c = 0; c < nlines; c++) run_line(c == 0, c == vlines);
  endtask

  task automatic ext_phase(input logic val, input int len, input bit chk,
                           input logic exp, input string tag);
    @(negedge clk);
    ext_coast = val;
    if (chk) push_chk(exp, tag, 2);
    repeat (len - 1) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hs_strobe = 1'b0; vs_in = 1'b0; ext_coast = 1'b0;
    cfg_src_ext = 1'b1; cfg_pol_force = 1'b0; cfg_pol_level = 1'b1;
    cfg_pre = 8'd2; cfg_post = 8'd3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    push_chk(1'b0, "R1 reset state", 1);
    repeat (2) @(negedge clk);

    // R10: only low phase measured, active high assumed
    ext_phase(1'b0, 5, 1'b0, 1'b0, "");
    ext_phase(1'b1, 4, 1'b1, 1'b1, "R10 default positive");
    ext_phase(1'b0, 4, 1'b0, 1'b0, "");

    // internal window
    cfg_src_ext = 1'b0;
    repeat (3) run_line(1'b0, 1'b0);        // R2 idle before any frame
    run_frame(10, 3);                        // R2 first frame unmeasured
    run_frame(10, 3);                        // R3 pre=2 post=3
    cfg_pre = 8'd0; cfg_post = 8'd0;
    run_frame(10, 3);                        // R4 R7
    cfg_pre = 8'd3; cfg_post = 8'd1;
    run_frame(12, 4);                        // R3 frame longer than predicted
    run_frame(12, 4);
    run_line(1'b0, 1'b0);                    // R3 waits for late vsync
    run_line(1'b0, 1'b0);

    // external, forced polarity
    cfg_src_ext = 1'b1; cfg_pol_force = 1'b1; cfg_pol_level = 1'b1;
    ext_phase(1'b1, 4, 1'b1, 1'b1, "R9 forced high pass");
    ext_phase(1'b0, 4, 1'b1, 1'b0, "R9 forced high pass");
    // R8: vertical sync has no effect on external coast
    @(negedge clk); vs_in = 1'b1;
    repeat (3) @(negedge clk);
    push_chk(1'b0, "R8 vsync ignored", 1);
    repeat (2) @(negedge clk); vs_in = 1'b0;
    repeat (2) @(negedge clk);
    cfg_pol_level = 1'b0;
    ext_phase(1'b1, 4, 1'b1, 1'b0, "R9 forced low invert");
    ext_phase(1'b0, 4, 1'b1, 1'b1, "R9 forced low invert");

    // automatic polarity
    cfg_pol_force = 1'b0;
    for (int k = 0; k < 3; k++) begin
      ext_phase(1'b1, 3, 1'b0, 1'b0, "");
      ext_phase(1'b0, 9, 1'b0, 1'b0, "");
    end
    ext_phase(1'b1, 3, 1'b1, 1'b1, "R10 short high active");
    ext_phase(1'b0, 9, 1'b1, 1'b0, "R10 short high active");
    for (int k = 0; k < 3; k++) begin
      ext_phase(1'b1, 9, 1'b0, 1'b0, "");
      ext_phase(1'b0, 3, 1'b0, 1'b0, "");
    end
    ext_phase(1'b1, 9, 1'b1, 1'b0, "R10 short low active");
    ext_phase(1'b0, 3, 1'b1, 1'b1, "R10 short low active");
    for (int k = 0; k < 3; k++) begin
      ext_phase(1'b1, 3, 1'b0, 1'b0, "");
      ext_phase(1'b0, 70, 1'b0, 1'b0, "");
    end
    ext_phase(1'b1, 3, 1'b1, 1'b1, "R10 saturated low phase");
    ext_phase(1'b0, 70, 1'b1, 1'b0, "R10 saturated low phase");

    repeat (6) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule